// File: doc/BRIEF.md
# Line Driver Bias Control Register

This block is the digital control of a two-port line driver. A host writes settings over a three-wire serial port: an active-low select, a serial clock and a data line. The block keeps one 8-bit settings register per port. Bit 7 of each register disables boost. Bits 6:0 hold the port's quiescent-current code, where one step is 0.5 mA in the analog bias generator. The block drives both current codes. It also drives one boost-enable line, formed from an external boost request and the two disable flags.

The serial pins are oversampled in the block's own clock domain through synchronizer chains. A frame is committed one cycle after its twelfth sampled rising serial-clock edge. The boost path is purely combinational, so the analog look-ahead timing of the boost request is kept.

Top module: `drv_bias_ctrl`

## Requirements
- R1: A frame is 12 bits, each taken on a rising serial-clock edge while select is low. The wire order is: one direction bit, then a 3-bit address sent LSB first, then an 8-bit value sent LSB first. A write frame (direction 1) to a decoded address loads that register with the value.
- R2: A read frame (direction 0) leaves both registers unchanged.
- R3: Address 3 selects the first port's register and address 7 selects the second port's register. Every other address leaves both registers unchanged.
- R4: Each port's current output equals bits 6:0 of that port's register. Bit 7 of the register is the port's boost-disable flag.
- R5: After reset both registers hold 8'h80. Both current outputs are 0 and boost-enable is low.
- R6: `boost_en_o` is high only when `boost_i` is high and at least one register has bit 7 clear.
- R7: While select is high, clock and data edges are ignored and the bit count returns to zero. A frame that is cut short by select rising is discarded, and the next frame is aligned from its first bit.
- R8: Within one select-low window only the first 12 bits count. Later bits change nothing.
- R9: `boost_en_o` follows `boost_i` with no clock cycle of delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock that oversamples the serial pins |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cs_ni | input | 1 | Serial select, active low |
| sclk_i | input | 1 | Serial clock, data sampled on its rising edge |
| sdata_i | input | 1 | Serial data |
| boost_i | input | 1 | External boost request |
| iq_ab_o | output | 7 | Quiescent-current code of the first port |
| iq_cd_o | output | 7 | Quiescent-current code of the second port |
| boost_en_o | output | 1 | Combined boost enable |

## Verification
The bench targets frames that are cut short by select rising after seven bits. A counter that is not cleared would misalign the next frame and write a garbled value to the wrong port. It sends frames with two extra trailing bits; a design that keeps shifting would commit a shifted value. Read frames and the undecoded addresses (including 1, 5 and 0) are sent, which would corrupt a register if the direction bit or the address decode were wrong. The boost line is walked through every mix of disable flags and request levels, with samples taken between clock edges so that a registered boost path or a wrong gate shows up.

// File: rtl/drv_bias_pkg.sv
package drv_bias_pkg;
  localparam int FRAME_W   = 12;
  localparam int ADDR_W    = 3;
  localparam int DATA_W    = 8;
  localparam int CODE_W    = DATA_W - 1;
  localparam int NUM_PORTS = 2;
  localparam logic [DATA_W-1:0] REG_RST = 8'h80;

  // packed so the LSB-first shift register maps straight onto the fields
  typedef struct packed {
    logic [DATA_W-1:0] data;
    logic [ADDR_W-1:0] addr;
    logic              wr;
  } frame_t;

  function automatic logic [ADDR_W-1:0] port_addr(input int p);
    return (p == 0) ? ADDR_W'(3) : ADDR_W'(7);
  endfunction
endpackage

// File: rtl/serial_frame_rx.sv
module serial_frame_rx
  import drv_bias_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   cs_ni,
  input  logic   sclk_i,
  input  logic   sdata_i,
  output logic   frame_vld_o,
  output frame_t frame_o
);
  localparam int CNT_W = $clog2(FRAME_W + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(FRAME_W - 1);

  logic [SYNC_STAGES-1:0] cs_sync_q, sclk_sync_q, sd_sync_q;
  logic                   sclk_prev_q;
  logic [CNT_W-1:0]       cnt_q;
  logic [FRAME_W-1:0]     sr_q, sr_next;
  logic                   cs_low, sclk_rise, sd_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_sync_q   <= '1;
      sclk_sync_q <= '0;
      sd_sync_q   <= '0;
      sclk_prev_q <= 1'b0;
    end else begin
      cs_sync_q   <= {cs_sync_q[SYNC_STAGES-2:0], cs_ni};
      sclk_sync_q <= {sclk_sync_q[SYNC_STAGES-2:0], sclk_i};
      sd_sync_q   <= {sd_sync_q[SYNC_STAGES-2:0], sdata_i};
      sclk_prev_q <= sclk_sync_q[SYNC_STAGES-1];
    end
  end

  assign cs_low    = ~cs_sync_q[SYNC_STAGES-1];
  assign sd_s      = sd_sync_q[SYNC_STAGES-1];
  assign sclk_rise = sclk_sync_q[SYNC_STAGES-1] & ~sclk_prev_q;
  assign sr_next   = {sd_s, sr_q[FRAME_W-1:1]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q       <= '0;
      sr_q        <= '0;
      frame_vld_o <= 1'b0;
      frame_o     <= '0;
    end else begin
      frame_vld_o <= 1'b0;
      if (!cs_low) begin
        cnt_q <= '0;
      end else if (sclk_rise && cnt_q != CNT_FULL) begin
        sr_q  <= sr_next;
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == CNT_LAST) begin
          frame_vld_o <= 1'b1;
          frame_o     <= frame_t'(sr_next);
        end
      end
    end
  end

  // R8
  cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_FULL);
  // R7
  cnt_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_low |=> cnt_q == '0);
  // R8
  one_commit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_vld_o |=> !frame_vld_o);
endmodule

// File: rtl/bias_reg_bank.sv
module bias_reg_bank
  import drv_bias_pkg::*;
(
  input  logic                               clk_i,
  input  logic                               rst_ni,
  input  logic                               frame_vld_i,
  input  frame_t                             frame_i,
  output logic [NUM_PORTS-1:0][DATA_W-1:0]   regs_o
);
  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    logic hit;
    assign hit = frame_vld_i && frame_i.wr && (frame_i.addr == port_addr(p));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  regs_o[p] <= REG_RST;
      else if (hit) regs_o[p] <= frame_i.data;
    end

    // R2 R3
    reg_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$stable(regs_o[p]) |-> $past(frame_vld_i && frame_i.wr && frame_i.addr == port_addr(p)));
  end
endmodule

// File: rtl/boost_gate.sv
module boost_gate
  import drv_bias_pkg::*;
(
  input  logic                 boost_i,
  input  logic [NUM_PORTS-1:0] dis_i,
  output logic                 boost_en_o
);
  // any port still allowing boost keeps the shared rail switching
  assign boost_en_o = boost_i & ~(&dis_i);
endmodule

// File: rtl/drv_bias_ctrl.sv
module drv_bias_ctrl
  import drv_bias_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              sclk_i,
  input  logic              sdata_i,
  input  logic              boost_i,
  output logic [CODE_W-1:0] iq_ab_o,
  output logic [CODE_W-1:0] iq_cd_o,
  output logic              boost_en_o
);
  logic                             frame_vld;
  frame_t                           frame;
  logic [NUM_PORTS-1:0][DATA_W-1:0] regs;
  logic [NUM_PORTS-1:0]             dis;

  serial_frame_rx #(.SYNC_STAGES(SYNC_STAGES)) i_rx (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cs_ni       (cs_ni),
    .sclk_i      (sclk_i),
    .sdata_i     (sdata_i),
    .frame_vld_o (frame_vld),
    .frame_o     (frame)
  );

  bias_reg_bank i_bank (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .frame_vld_i (frame_vld),
    .frame_i     (frame),
    .regs_o      (regs)
  );

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_dis
    assign dis[p] = regs[p][DATA_W-1];
  end

  boost_gate i_boost (
    .boost_i    (boost_i),
    .dis_i      (dis),
    .boost_en_o (boost_en_o)
  );

  assign iq_ab_o = regs[0][CODE_W-1:0];
  assign iq_cd_o = regs[1][CODE_W-1:0];

  // R6
  boost_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !boost_i |-> !boost_en_o);
  // R6
  all_dis_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&dis) |-> !boost_en_o);
endmodule

// File: tb/test_drv_bias_ctrl.sv
module test_drv_bias_ctrl;
  localparam int HALF = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n = 1'b1, sclk = 1'b0, sdata = 1'b0, boost = 1'b0;
  logic [6:0] iq_ab, iq_cd;
  logic boost_en;

  int n_chk = 0, n_fail = 0, cyc = 0;
  logic [7:0] exp_ab = 8'h80, exp_cd = 8'h80;

  always #10 clk = ~clk;

  drv_bias_ctrl i_drv_bias_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .sclk_i(sclk), .sdata_i(sdata),
    .boost_i(boost), .iq_ab_o(iq_ab), .iq_cd_o(iq_cd), .boost_en_o(boost_en)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      n_fail++;
      $display("FAIL watchdog: got %0d cycles, expected fewer", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  function automatic logic exp_boost(input logic b, input logic [7:0] ab, input logic [7:0] cd);
    return b & ~(ab[7] & cd[7]);
  endfunction

  function automatic logic [15:0] mk(input logic dir, input logic [2:0] addr, input logic [7:0] data);
    return {4'h0, data, addr, dir};
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check_all(input string req);
    chk(req, "iq_ab", int'(iq_ab), int'(exp_ab[6:0]));
    chk(req, "iq_cd", int'(iq_cd), int'(exp_cd[6:0]));
    for (int b = 0; b < 2; b++) begin
      boost = b[0];
      #1;
      chk(req, "boost_en", int'(boost_en), int'(exp_boost(b[0], exp_ab, exp_cd)));
    end
    boost = 1'b0;
  endtask

  task automatic shift_bit(input logic b);
    sdata = b;
    wait_clk(HALF);
    sclk = 1'b1;
    wait_clk(HALF);
    sclk = 1'b0;
  endtask

  // n bits of w in window; model applies first 12 when n >= 12
  task automatic send(input logic [15:0] w, input int n);
    cs_n = 1'b0;
    wait_clk(HALF);
    for (int i = 0; i < n; i++) shift_bit(w[i]);
    wait_clk(HALF);
    cs_n = 1'b1;
    sdata = 1'b0;
    wait_clk(8);
    if (n >= 12 && w[0]) begin
      if (w[3:1] == 3'd3) exp_ab = w[11:4];
      if (w[3:1] == 3'd7) exp_cd = w[11:4];
    end
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    wait_clk(3);
    // R5 reset state
    check_all("R5");
    rst_n = 1'b1;
    wait_clk(3);
    check_all("R5");

    // R1 R4 directed writes
    send(mk(1'b1, 3'd3, 8'h1C), 12); check_all("R1");
    send(mk(1'b1, 3'd7, 8'h7F), 12); check_all("R4");
    // R2 read frame ignored
    send(mk(1'b0, 3'd3, 8'h55), 12); check_all("R2");
    send(mk(1'b0, 3'd7, 8'h2A), 12); check_all("R2");
    // R3 undecoded addresses
    send(mk(1'b1, 3'd1, 8'h00), 12); check_all("R3");
    send(mk(1'b1, 3'd5, 8'h11), 12); check_all("R3");
    send(mk(1'b1, 3'd0, 8'h22), 12); check_all("R3");

    // R7 partial frame then clean frame
    send(mk(1'b1, 3'd3, 8'hFF), 7);  check_all("R7");
    send(mk(1'b1, 3'd7, 8'h0F), 12); check_all("R7");
    // R7 clock toggling with select high
    for (int i = 0; i < 12; i++) begin
      sdata = 1'b1; wait_clk(HALF); sclk = 1'b1; wait_clk(HALF); sclk = 1'b0;
    end
    wait_clk(8);
    check_all("R7");
    send(mk(1'b1, 3'd3, 8'h05), 12); check_all("R7");

    // R8 trailing bits ignored
    send({2'b11, 2'b00, 8'h33, 3'd7, 1'b1}, 14); check_all("R8");
    send({2'b01, 2'b00, 8'hC2, 3'd3, 1'b1}, 14); check_all("R8");

    // R6 disable flag combinations
    send(mk(1'b1, 3'd3, 8'h80), 12); send(mk(1'b1, 3'd7, 8'h90), 12); check_all("R6");
    send(mk(1'b1, 3'd7, 8'h10), 12); check_all("R6");
    send(mk(1'b1, 3'd3, 8'h01), 12); send(mk(1'b1, 3'd7, 8'h81), 12); check_all("R6");

    // R9 boost follows without a clock edge
    @(posedge clk); #2;
    boost = 1'b1; #1;
    chk("R9", "boost_en rise", int'(boost_en), int'(exp_boost(1'b1, exp_ab, exp_cd)));
    boost = 1'b0; #1;
    chk("R9", "boost_en fall", int'(boost_en), 0);

    // R1 random frames
    for (int k = 0; k < 60; k++) begin
      logic dir;
      logic [2:0] addr;
      logic [7:0] data;
      int sel;
      dir  = ($urandom % 4) != 0;
      sel  = $urandom % 3;
      addr = (sel == 0) ? 3'd3 : (sel == 1) ? 3'd7 : 3'($urandom);
      data = 8'($urandom);
      send(mk(dir, addr, data), 12);
      check_all("R1");
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule